// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block turns an operand specifier into a final memory address for a machine with a general register file. A specifier has three parts: a 3-bit addressing mode, an address field `x`, and two register numbers. One register number names an index register and the other names a base register. The unit reads both registers through a two-port read interface during the cycle in which `start` is high, and it captures everything it needs on that clock edge.

Modes that use only registers and `x` finish in the next cycle. The three indirect modes need a pointer word from memory. For these the unit holds a read request on its memory port until read-valid comes back, then forms the address from the returned word.

Both orders of indexing and indirection are supported: the index can be added after the pointer fetch, or before it. All sums wrap modulo 2^AW. The unit does not fetch the operand itself, and instruction decoding happens elsewhere.

Top module: `eag_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` and `mem_req` are 0 and `ea` is 0.
- R2: Mode encodings are 0 absolute, 1 indexed, 2 indirect, 3 post-indexed indirect, 4 pre-indexed indirect, 5 register-indirect, 6 base-plus-index, and 7 is handled as absolute. In absolute mode `ea` becomes `x` and `done` is high in the cycle after the `start` cycle, with no memory request.
- R3: Indexed mode gives `ea` = (`x` + R[idx]) mod 2^AW, with `done` one cycle after `start`.
- R4: Register-indirect mode gives `ea` = R[idx], with `done` one cycle after `start`.
- R5: Base-plus-index mode gives `ea` = (R[idx] + R[base]) mod 2^AW, with `done` one cycle after `start`. This holds even when both register numbers are the same.
- R6: Indirect mode raises `mem_req` in the cycle after `start`, with `mem_addr` = `x`. The final `ea` is the returned word.
- R7: Post-indexed indirect mode reads at `x`. The final `ea` is (word + R[idx]) mod 2^AW, where R[idx] is the value read in the `start` cycle.
- R8: Pre-indexed indirect mode reads at (`x` + R[idx]) mod 2^AW. The final `ea` is the returned word.
- R9: `mem_req` and `mem_addr` stay constant until `mem_rvalid` is sampled high, and this works for a latency of zero or more cycles. In the cycle after that edge, `done` is high and `mem_req` is low. `ea` changes only in a cycle where `done` is high.
- R10: A `start` received while a memory read is pending is ignored. A `mem_rvalid` received while no request is pending is ignored.
- R11: `rf_raddr_a` follows `idx_sel` and `rf_raddr_b` follows `base_sel`. Register data is sampled only in the `start` cycle, so later changes to the registers do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address calculation (taken only when idle) |
| mode | input | 3 | Addressing mode |
| addr_x | input | AW | Address field of the specifier |
| idx_sel | input | RW | Index register number |
| base_sel | input | RW | Base register number |
| rf_raddr_a | output | RW | Register read port A address |
| rf_rdata_a | input | AW | Register read port A data |
| rf_raddr_b | output | RW | Register read port B address |
| rf_rdata_b | input | AW | Register read port B data |
| mem_req | output | 1 | Pointer read request, held until valid |
| mem_addr | output | AW | Pointer read address |
| mem_rvalid | input | 1 | Pointer word valid |
| mem_rdata | input | AW | Pointer word |
| ea | output | AW | Effective address (held between results) |
| done | output | 1 | One-cycle strobe: `ea` is new |

## Verification
The assertions check the following on every cycle:
- the fixed latencies: one cycle from an accepted direct start to `done`, and one cycle from an accepted read to `done`;
- that the request and its address stay stable while waiting;
- that `ea` never moves without `done`;
- that no start is accepted while a read is pending.

The address values themselves cannot be checked that way. Only the bench's scenarios show them: the arithmetic of each mode, wrap-around, pre- versus post-indexing, the capture of register values at start, and the cases where a stray start or stray valid is ignored. The bench compares these against its own reference model, using a memory with random latency.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    EA_ABS   = 3'd0,
    EA_IDX   = 3'd1,
    EA_IND   = 3'd2,
    EA_POST  = 3'd3,
    EA_PRE   = 3'd4,
    EA_RIND  = 3'd5,
    EA_RBASE = 3'd6,
    EA_ALT   = 3'd7
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;

endpackage

// File: rtl/eag_operand.sv
module eag_operand
  import eag_pkg::*;
#(
  parameter int AW = 16
) (
  input  ea_mode_e        mode,
  input  logic [AW-1:0]   x,
  input  logic [AW-1:0]   ri,
  input  logic [AW-1:0]   rb,
  output logic [AW-1:0]   direct_ea,
  output logic [AW-1:0]   ptr,
  output logic            needs_mem,
  output logic            post_add
);

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  always_comb begin
    direct_ea = x;
    ptr       = x;
    needs_mem = 1'b0;
    post_add  = 1'b0;
    unique case (mode)
      EA_IDX:   direct_ea = wrap_add(x, ri);
      EA_RIND:  direct_ea = ri;
      EA_RBASE: direct_ea = wrap_add(ri, rb);
      EA_IND:   needs_mem = 1'b1;
      EA_POST: begin
        needs_mem = 1'b1;
        post_add  = 1'b1;
      end
      EA_PRE: begin
        needs_mem = 1'b1;
        ptr       = wrap_add(x, ri);
      end
      default:  direct_ea = x;
    endcase
  end

endmodule

// File: rtl/eag_resolve.sv
module eag_resolve #(
  parameter int AW = 16
) (
  input  logic            post_q,
  input  logic [AW-1:0]   ri_q,
  input  logic [AW-1:0]   word,
  output logic [AW-1:0]   final_ea
);

  function automatic logic [AW-1:0] apply_post(input logic en, input logic [AW-1:0] w,
                                               input logic [AW-1:0] r);
    return en ? w + r : w;
  endfunction

  assign final_ea = apply_post(post_q, word, ri_q);

endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic needs_mem,
  input  logic mem_rvalid,
  output logic accept_direct,
  output logic accept_indirect,
  output logic mem_fire,
  output logic waiting
);

  ea_state_e state_q;
  logic      idle;

  assign idle            = (state_q == ST_IDLE);
  assign waiting         = (state_q == ST_WAIT);
  assign accept_direct   = idle && start && !needs_mem;
  assign accept_indirect = idle && start && needs_mem;
  assign mem_fire        = waiting && mem_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (accept_indirect) begin
      state_q <= ST_WAIT;
    end else if (mem_fire) begin
      state_q <= ST_IDLE;
    end
  end

endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] addr_x,
  input  logic [RW-1:0] idx_sel,
  input  logic [RW-1:0] base_sel,
  output logic [RW-1:0] rf_raddr_a,
  input  logic [AW-1:0] rf_rdata_a,
  output logic [RW-1:0] rf_raddr_b,
  input  logic [AW-1:0] rf_rdata_b,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] ea,
  output logic          done
);

  logic [AW-1:0] direct_ea, ptr, final_ea;
  logic          needs_mem, post_add;
  logic          accept_direct, accept_indirect, mem_fire, waiting;
  logic [AW-1:0] ptr_q, ri_q;
  logic          post_q;

  assign rf_raddr_a = idx_sel;
  assign rf_raddr_b = base_sel;

  eag_operand #(.AW(AW)) i_operand (
    .mode      (ea_mode_e'(mode)),
    .x         (addr_x),
    .ri        (rf_rdata_a),
    .rb        (rf_rdata_b),
    .direct_ea (direct_ea),
    .ptr       (ptr),
    .needs_mem (needs_mem),
    .post_add  (post_add)
  );

  eag_seq i_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .needs_mem       (needs_mem),
    .mem_rvalid      (mem_rvalid),
    .accept_direct   (accept_direct),
    .accept_indirect (accept_indirect),
    .mem_fire        (mem_fire),
    .waiting         (waiting)
  );

  eag_resolve #(.AW(AW)) i_resolve (
    .post_q   (post_q),
    .ri_q     (ri_q),
    .word     (mem_rdata),
    .final_ea (final_ea)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ri_q   <= '0;
      post_q <= 1'b0;
    end else if (accept_indirect) begin
      ptr_q  <= ptr;
      ri_q   <= rf_rdata_a;
      post_q <= post_add;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea   <= '0;
      done <= 1'b0;
    end else begin
      done <= accept_direct || mem_fire;
      if (accept_direct) begin
        ea <= direct_ea;
      end else if (mem_fire) begin
        ea <= final_ea;
      end
    end
  end

  assign mem_req  = waiting;
  assign mem_addr = ptr_q;

endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic [AW-1:0] ea,
  input logic          accept_direct,
  input logic          accept_indirect,
  input logic          mem_fire
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done && !mem_req && ea == '0);

  // R2
  direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_direct |=> done && !mem_req);

  // R6
  request_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_indirect |=> mem_req && !done);

  // R9
  request_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && !done);

  // R9
  fire_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |=> done && !mem_req);

  // R9
  ea_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ea) |-> done);

  // R10
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_direct || accept_indirect) |-> !mem_req);

  // R10
  stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && !accept_direct |=> !done);

endmodule

bind eag_unit eag_unit_chk #(.AW(AW)) i_eag_unit_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .done            (done),
  .mem_req         (mem_req),
  .mem_addr        (mem_addr),
  .mem_rvalid      (mem_rvalid),
  .ea              (ea),
  .accept_direct   (accept_direct),
  .accept_indirect (accept_indirect),
  .mem_fire        (mem_fire)
);

// File: tb/test_eag_unit.sv
module test_eag_unit;
  localparam int AW = 16;
  localparam int RW = 3;
  localparam int NR = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [AW-1:0] addr_x = '0;
  logic [RW-1:0] idx_sel = '0, base_sel = '0;
  wire  [RW-1:0] rf_raddr_a, rf_raddr_b;
  logic [AW-1:0] rf [NR];
  wire  [AW-1:0] rf_rdata_a = rf[rf_raddr_a];
  wire  [AW-1:0] rf_rdata_b = rf[rf_raddr_b];
  wire           mem_req;
  wire  [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  wire  [AW-1:0] ea;
  wire           done;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  eag_unit #(.AW(AW), .RW(RW)) i_eag_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_x(addr_x),
    .idx_sel(idx_sel), .base_sel(base_sel),
    .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
    .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ea(ea), .done(done)
  );

  function automatic logic [AW-1:0] memfn(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction

  function automatic logic [AW-1:0] sum16(input int a, input int b);
    return AW'((a + b) % 65536);
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [AW-1:0] x, input logic [RW-1:0] i,
                        input logic [RW-1:0] b, input int lat, input bit poke_start,
                        input bit poke_rf);
    logic [AW-1:0] ri, rb, exp, ptr, old_ea;
    bit ind;
    string tag;
    ri = rf[i];
    rb = rf[b];
    ind = 1'b0;
    ptr = x;
    case (m)
      3'd1: begin exp = sum16(int'(x), int'(ri)); tag = "R3 R11"; end
      3'd2: begin ind = 1'b1; exp = memfn(x); tag = "R6"; end
      3'd3: begin ind = 1'b1; exp = sum16(int'(memfn(x)), int'(ri)); tag = "R7 R11"; end
      3'd4: begin ind = 1'b1; ptr = sum16(int'(x), int'(ri)); exp = memfn(ptr); tag = "R8 R11"; end
      3'd5: begin exp = ri; tag = "R4 R11"; end
      3'd6: begin exp = sum16(int'(ri), int'(rb)); tag = "R5 R11"; end
      default: begin exp = x; tag = "R2"; end
    endcase
    @(negedge clk);
    old_ea = ea;
    start = 1'b1; mode = m; addr_x = x; idx_sel = i; base_sel = b;
    @(negedge clk);
    start = 1'b0;
    if (!ind) begin
      check(done && !mem_req, {tag, " done"}, AW'({done, mem_req}), AW'(2'b10));
      check(ea == exp, {tag, " ea"}, ea, exp);
    end else begin
      check(mem_req && !done, {tag, " req"}, AW'({mem_req, done}), AW'(2'b10));
      check(mem_addr == ptr, {tag, " addr"}, mem_addr, ptr);
      if (poke_rf) begin
        rf[i] = ~rf[i];
        rf[b] = rf[b] + 16'h1111;
      end
      for (int k = 0; k < lat; k++) begin
        if (poke_start && k == 0) begin
          start = 1'b1; mode = 3'd0; addr_x = ~x;
        end
        @(negedge clk);
        start = 1'b0;
        check(mem_req && !done && mem_addr == ptr, "R9 R10 wait", mem_addr, ptr);
        check(ea == old_ea, "R9 hold", ea, old_ea);
      end
      mem_rvalid = 1'b1;
      mem_rdata = memfn(mem_addr);
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata = 16'hDEAD;
      check(done && !mem_req, "R9 done", AW'({done, mem_req}), AW'(2'b10));
      check(ea == exp, {tag, " ea"}, ea, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    logic [AW-1:0] keep;
    unused_seed = $urandom(32'd1234);
    for (int r = 0; r < NR; r++) rf[r] = AW'(16'h0100 * r + 16'h0011);
    repeat (3) @(negedge clk);
    check(!done && !mem_req && ea == '0, "R1 in reset", ea, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_req && ea == '0, "R1 after reset", ea, '0);

    run_op(3'd0, 16'h1234, 3'd0, 3'd0, 0, 0, 0);
    run_op(3'd7, 16'hBEEF, 3'd1, 3'd2, 0, 0, 0);
    rf[2] = 16'h0002;
    run_op(3'd1, 16'hFFFF, 3'd2, 3'd0, 0, 0, 0);
    run_op(3'd5, 16'h0000, 3'd3, 3'd0, 0, 0, 0);
    rf[4] = 16'h8001; rf[5] = 16'h8000;
    run_op(3'd6, 16'h0000, 3'd4, 3'd5, 0, 0, 0);
    run_op(3'd6, 16'h0000, 3'd4, 3'd4, 0, 0, 0);
    run_op(3'd2, 16'h00A0, 3'd0, 3'd0, 0, 0, 0);
    run_op(3'd3, 16'h0F00, 3'd6, 3'd0, 3, 1, 1);
    rf[7] = 16'hFFF0;
    run_op(3'd4, 16'h0020, 3'd7, 3'd1, 2, 1, 1);

    keep = ea;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 16'h5555;
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(!done && !mem_req, "R10 stray valid", AW'({done, mem_req}), '0);
    check(ea == keep, "R10 stray valid ea", ea, keep);

    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0) rf[$urandom % NR] = AW'($urandom);
      run_op(3'($urandom % 8), AW'($urandom), RW'($urandom), RW'($urandom),
             int'($urandom % 5), bit'($urandom % 2), bit'($urandom % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule